// File: doc/BRIEF.md
# Burst-Mode Resolution Sequencer

This block sits on the sample path of a 12-bit converter and decides, one sample at a time, whether each output word leaves at full resolution or with its four least significant bits cleared. When burst mode is switched on it first holds the output in reduced resolution for a fixed initial lockout. After that it lets a full-resolution burst of 2^N samples through. The burst is started either by a rising edge on an external trigger line or automatically. Every burst is followed by a lockout of 2^(N+3) reduced-resolution samples. A ready flag tells the system when a new burst may be requested. A resolution flag marks the full-resolution samples.

The sequencer is a six-state machine:
- IDLE: burst mode off, data passes unchanged.
- INIT_LOCK: initial lockout.
- READY: waiting for a trigger.
- ARM: one cycle of trigger latency.
- BURST: full-resolution samples.
- POST_LOCK: lockout after a burst.

Its transitions are:
- enable (IDLE to INIT_LOCK).
- init_done (INIT_LOCK to READY in manual mode, or to BURST in auto mode).
- trigger_edge (READY to ARM).
- arm_done (ARM to BURST).
- auto_go (READY to BURST when auto mode is selected).
- burst_done (BURST to POST_LOCK).
- lock_done (POST_LOCK to READY in manual mode, or to BURST in auto mode).
- disable (any state to IDLE when enable is low).

All outputs are registered. Each output word reflects the state and the input sample of the previous cycle.

Top module: `burst_res_seq`

## Requirements
- R1: While reset is asserted, `dout` is zero and `trdy` and `hres` are low.
- R2: While `burst_en` is low (state IDLE), each output word equals the input sample of the previous cycle with all 12 bits kept, and `trdy` and `hres` are low.
- R3: After `burst_en` rises, exactly 2^INIT_LOG reduced-resolution words are output with both flags low. A reduced-resolution word is bits 11:4 of the sample with bits 3:0 forced to zero. Any trigger activity in this period has no effect.
- R4: In manual mode (`auto_trig` low), `trdy` is high during READY and stays high until a low-to-high change of `trig_in` is seen at a clock edge. A trigger line that rose during a lockout and is still high does not start a burst.
- R5: The first full-resolution word appears on the third output word after the edge at which the trigger rise is sampled. The two words in between are reduced-resolution; the first has `trdy` high and the second has `trdy` low.
- R6: A burst is exactly 2^N consecutive full-resolution words. `hres` is high on exactly those words.
- R7: Immediately after a burst, exactly 2^(N+3) reduced-resolution words follow with both flags low, and triggers are ignored. In manual mode the next word after them shows `trdy` high again.
- R8: In auto mode, `trig_in` is ignored. A burst starts right after the initial lockout and right after every post-burst lockout.
- R9: In auto mode, `trdy` is high only on the first full-resolution word of each burst.
- R10: The value of `n_exp` sampled when a burst starts sets that burst's length. The value sampled at the last burst sample sets the following lockout's length, so a change of N during a burst acts on that lockout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_en | input | 1 | Burst mode enable |
| auto_trig | input | 1 | Selects automatic bursts instead of the trigger line |
| n_exp | input | 4 | Burst exponent N |
| trig_in | input | 1 | External trigger line, rising-edge sensitive |
| din | input | 12 | Full-resolution sample |
| dout | output | 12 | Output sample word |
| trdy | output | 1 | Ready for a new trigger (a pulse in auto mode) |
| hres | output | 1 | Marks full-resolution output words |

## Verification
The hardest situation to reach is N changing exactly between the latch that sets a burst's length and the latch that sets the following lockout. For N = 0 both latches fall on adjacent edges. The bench times the change of `n_exp` to the output word just before the first full-resolution word. It sweeps N from 0 to 3 in both modes, so each lockout length differs from the burst that preceded it. A trigger is also raised inside every lockout and held into READY, to show that a stale level starts nothing.

// File: rtl/burst_res_seq_pkg.sv
package burst_res_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_INIT_LOCK = 3'd1,
        ST_READY     = 3'd2,
        ST_ARM       = 3'd3,
        ST_BURST     = 3'd4,
        ST_POST_LOCK = 3'd5
    } seq_state_e;

    function automatic logic is_counting(input seq_state_e st);
        return (st == ST_INIT_LOCK) || (st == ST_BURST) || (st == ST_POST_LOCK);
    endfunction

endpackage

// File: rtl/burst_trig_edge.sv
module burst_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_in;
    end

    // A rise is a high sample following a low sample
    assign trig_rise = trig_in & ~trig_q;
endmodule

// File: rtl/burst_seg_counter.sv
module burst_seg_counter #(
    parameter int CNT_W = 18,
    parameter int LOG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [LOG_W-1:0] len_log,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

    logic [CNT_W:0] span;

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + CNT_W'(1);
    end

    // Terminal count is 2^len_log - 1
    always_comb begin
        span = (ONE << len_log) - ONE;
        last = ({1'b0, cnt} == span);
    end
endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage #(
    parameter int DATA_W = 12,
    parameter int LOW_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_full,
    input  logic              sel_hres,
    input  logic              sel_trdy,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              trdy,
    output logic              hres
);
    localparam int HIGH_W = DATA_W - LOW_W;

    logic [DATA_W-1:0] word_nx;

    always_comb begin
        if (sel_full) word_nx = din;
        else          word_nx = {din[DATA_W-1 -: HIGH_W], {LOW_W{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            trdy <= 1'b0;
            hres <= 1'b0;
        end else begin
            dout <= word_nx;
            trdy <= sel_trdy;
            hres <= sel_hres;
        end
    end

    // A ready flag coinciding with a burst word is the auto pulse: one cycle only
    assert_auto_trdy_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && hres) |=> !trdy);

    // Reduced-resolution words never carry low bits
    assert_low_bits_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_full) |=> (dout[LOW_W-1:0] == '0));
endmodule

// File: rtl/burst_res_seq.sv
module burst_res_seq
    import burst_res_seq_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int LOW_W    = 4,
    parameter int N_W      = 4,
    parameter int INIT_LOG = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_en,
    input  logic              auto_trig,
    input  logic [N_W-1:0]    n_exp,
    input  logic              trig_in,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              trdy,
    output logic              hres
);
    localparam int POST_OFS = 3;
    localparam int N_MAX    = (2 ** N_W) - 1 + POST_OFS;
    localparam int MAX_LOG  = (INIT_LOG > N_MAX) ? INIT_LOG : N_MAX;
    localparam int CNT_W    = MAX_LOG;
    localparam int LOG_W    = $clog2(MAX_LOG + 1);

    seq_state_e       state, state_nx;
    logic             trig_rise;
    logic [N_W-1:0]   n_cur;
    logic [LOG_W-1:0] len_log;
    logic [CNT_W-1:0] cnt;
    logic             cnt_last;
    logic             seg_clr;
    logic             sel_full, sel_hres, sel_trdy;

    burst_trig_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_rise (trig_rise)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (burst_en) state_nx = ST_INIT_LOCK;
            ST_INIT_LOCK: if (cnt_last) state_nx = auto_trig ? ST_BURST : ST_READY;
            ST_READY: begin
                if (auto_trig)      state_nx = ST_BURST;
                else if (trig_rise) state_nx = ST_ARM;
            end
            ST_ARM:       state_nx = ST_BURST;
            ST_BURST:     if (cnt_last) state_nx = ST_POST_LOCK;
            ST_POST_LOCK: if (cnt_last) state_nx = auto_trig ? ST_BURST : ST_READY;
            default:      state_nx = ST_IDLE;
        endcase
        if (!burst_en) state_nx = ST_IDLE;
    end

    assign seg_clr = (state_nx != state);

    // Exponent is captured on entry to a burst and on entry to a lockout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_cur <= '0;
        end else if (seg_clr && (state_nx == ST_BURST || state_nx == ST_POST_LOCK)) begin
            n_cur <= n_exp;
        end
    end

    // Segment length selection
    always_comb begin
        unique case (state)
            ST_INIT_LOCK: len_log = LOG_W'(INIT_LOG);
            ST_BURST:     len_log = LOG_W'(n_cur);
            ST_POST_LOCK: len_log = LOG_W'(n_cur) + LOG_W'(POST_OFS);
            default:      len_log = '0;
        endcase
    end

    burst_seg_counter #(
        .CNT_W (CNT_W),
        .LOG_W (LOG_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (seg_clr),
        .inc     (is_counting(state)),
        .len_log (len_log),
        .cnt     (cnt),
        .last    (cnt_last)
    );

    // Output selection per state
    always_comb begin
        sel_full = 1'b0;
        sel_hres = 1'b0;
        sel_trdy = 1'b0;
        unique case (state)
            ST_IDLE:  sel_full = 1'b1;
            ST_READY: sel_trdy = 1'b1;
            ST_BURST: begin
                sel_full = 1'b1;
                sel_hres = 1'b1;
                sel_trdy = auto_trig && (cnt == '0);
            end
            default: ;
        endcase
    end

    burst_out_stage #(
        .DATA_W (DATA_W),
        .LOW_W  (LOW_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_full (sel_full),
        .sel_hres (sel_hres),
        .sel_trdy (sel_trdy),
        .din      (din),
        .dout     (dout),
        .trdy     (trdy),
        .hres     (hres)
    );

    assert_idle_on_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_en) |=> (state == ST_IDLE));

    assert_init_ignores_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT_LOCK && !cnt_last && burst_en) |=> (state == ST_INIT_LOCK));

    assert_edge_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && burst_en && !auto_trig && trig_rise) |=> (state == ST_ARM));

    assert_arm_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && burst_en) |=> (state == ST_BURST && cnt == '0));

    assert_post_ignores_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST_LOCK && !cnt_last && burst_en) |=> (state == ST_POST_LOCK));

    assert_exp_held_in_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !cnt_last) |=> $stable(n_cur));

    assert_auto_never_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST_LOCK && cnt_last && burst_en && auto_trig) |=> (state == ST_BURST));
endmodule

// File: tb/burst_res_seq_tb.sv
module burst_res_seq_tb;
    localparam int INIT_LOG = 6;
    localparam int LOCK0    = 2 ** INIT_LOG;
    localparam int M_FULL   = 0;
    localparam int M_LOW    = 1;
    localparam int M_SKIP   = 2;

    logic        clk = 1'b0;
    logic        rst_n, burst_en, auto_trig, trig_in;
    logic [3:0]  n_exp;
    logic [11:0] din, last_din;
    logic [11:0] dout;
    logic        trdy, hres;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;

    always #4 clk = ~clk;

    burst_res_seq #(
        .DATA_W   (12),
        .LOW_W    (4),
        .N_W      (4),
        .INIT_LOG (INIT_LOG)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .burst_en  (burst_en),
        .auto_trig (auto_trig),
        .n_exp     (n_exp),
        .trig_in   (trig_in),
        .din       (din),
        .dout      (dout),
        .trdy      (trdy),
        .hres      (hres)
    );

    // Check the word produced from the previous sample, then drive a new sample
    task automatic cyc(input int mode, input logic et, input logic eh, input string tag);
        logic [11:0] exp_w;
        @(negedge clk);
        if (mode != M_SKIP) begin
            exp_w = (mode == M_FULL) ? last_din : {last_din[11:4], 4'h0};
            checks++;
            if (dout !== exp_w || trdy !== et || hres !== eh) begin
                fails++;
                $display("FAIL %s: dout=%h trdy=%b hres=%b, expected dout=%h trdy=%b hres=%b",
                         tag, dout, trdy, hres, exp_w, et, eh);
            end
        end
        din      = 12'($urandom_range(0, 4095));
        last_din = din;
    endtask

    task automatic seg(input int n, input int mode, input logic et, input logic eh,
                       input bit toggle, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(mode, et, eh, tag);
            if (toggle) trig_in = ~trig_in;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int nn;
        rst_n = 1'b0; burst_en = 1'b0; auto_trig = 1'b0; trig_in = 1'b0;
        n_exp = 4'd0; din = 12'h5A5; last_din = din;
        repeat (3) @(negedge clk);
        checks++;
        if (dout !== 12'h000 || trdy !== 1'b0 || hres !== 1'b0) begin
            fails++;
            $display("FAIL R1: dout=%h trdy=%b hres=%b, expected 000 0 0", dout, trdy, hres);
        end
        rst_n = 1'b1;
        cyc(M_SKIP, 0, 0, "R2");
        seg(5, M_FULL, 0, 0, 0, "R2 idle pass-through");

        // Manual mode
        burst_en = 1'b1;
        cyc(M_FULL, 0, 0, "R2 last idle word");
        seg(10, M_LOW, 0, 0, 0, "R3 initial lockout");
        trig_in = 1'b1;
        seg(LOCK0 - 10, M_LOW, 0, 0, 0, "R3 trigger ignored in lockout");
        seg(5, M_LOW, 1, 0, 0, "R4 held trigger starts nothing");
        trig_in = 1'b0;
        seg(2, M_LOW, 1, 0, 0, "R4 ready waits");
        for (int k = 0; k < 4; k++) begin
            nn = (k + 1) % 4;
            trig_in = 1'b1;
            cyc(M_LOW, 1, 0, "R5 edge cycle");
            cyc(M_LOW, 0, 0, "R5 latency cycle");
            n_exp = 4'(nn);
            trig_in = 1'b0;
            seg(2 ** k, M_FULL, 0, 1, 0, "R6 manual burst");
            seg(3, M_LOW, 0, 0, 0, "R7 post lockout");
            trig_in = 1'b1;
            seg((2 ** (nn + 3)) - 3, M_LOW, 0, 0, 0, "R10 lockout uses new N");
            seg(2, M_LOW, 1, 0, 0, "R7 ready after lockout");
            trig_in = 1'b0;
            cyc(M_LOW, 1, 0, "R4 falling trigger ignored");
        end
        burst_en = 1'b0;
        cyc(M_SKIP, 0, 0, "R2");
        seg(3, M_FULL, 0, 0, 0, "R2 disable returns to idle");

        // Auto mode
        auto_trig = 1'b1;
        n_exp = 4'd0;
        burst_en = 1'b1;
        cyc(M_FULL, 0, 0, "R2 last idle word");
        seg(LOCK0, M_LOW, 0, 0, 1, "R8 initial lockout, trigger toggling");
        for (int k = 0; k < 4; k++) begin
            nn = (k + 1) % 4;
            n_exp = 4'(nn);
            cyc(M_FULL, 1, 1, "R9 auto ready pulse");
            seg((2 ** k) - 1, M_FULL, 0, 1, 1, "R6 auto burst");
            seg(2 ** (nn + 3), M_LOW, 0, 0, 1, "R8 auto lockout ignores trigger");
        end
        cyc(M_FULL, 1, 1, "R8 bursts chain");
        burst_en = 1'b0;
        cyc(M_SKIP, 0, 0, "R2");
        seg(3, M_FULL, 0, 0, 0, "R2 auto disable");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule